// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two parallel buses, called A and B, and can pass data either way or hold a copy of each bus. Each side owns a capture register with its own clock. On a rising edge, that register samples the value present on its bus pin. The value comes from the external source when the block is not driving that pin, and from the block's own drive when it is.

Each direction has a drive enable and a source select. The A-to-B enable is active high and the B-to-A enable is active low, so a single control pattern can turn both drivers on at once. The source select picks either the live value from the opposite bus or the contents of the register for that direction.

Pins are split into separate value-in, value-out and drive-enable ports, so no bidirectional net exists inside the block. Sometimes both directions are enabled with live data, and each bus then drives the other. For that case the block holds the last bus value in a feedback keeper. This copies how a pair of back-to-back drivers latches a floating bus.

Top module: `xcvr_reg_transceiver`

## Requirements
- R1: On a rising edge of `a2b_clk`, the A-side register loads the A pin value. On a rising edge of `b2a_clk`, the B-side register loads the B pin value. This happens at every enable and select setting.
- R2: With `a2b_en` low and `b2a_en_n` high, neither pin is driven: `a_pad_oe` = 0 and `b_pad_oe` = 0.
- R3: `b_pad_oe` follows `a2b_en` (active high) and `a_pad_oe` follows the inverse of `b2a_en_n` (active low). The two are independent of each other.
- R4: When a select is low (live) and the feedback loop of R6 is not formed, the driven output is the opposite side's `*_pad_i` value: `b_pad_o` = `a_pad_i`, `a_pad_o` = `b_pad_i`.
- R5: When a select is high (stored), the driven output is that direction's register. `b_pad_o` is the A-side register and `a_pad_o` is the B-side register. Both buses can be driven this way at once.
- R6: The feedback loop is formed when `a2b_en`=1, `b2a_en_n`=0 and both selects are 0. In that state both outputs carry the A-bus value from just before the loop formed. They keep it whatever `a_pad_i` and `b_pad_i` do. Register captures during the loop store that held value.
- R7: A pin that the block drives is captured from the block's own drive. With A driving B live, a `b2a_clk` edge stores the A data. With B-to-A stored, a `b2a_clk` edge followed later by an `a2b_clk` edge loads the B data into both registers.
- R8: Reset is synchronous and active low. When `rst_n` is low at a register's clock edge, that register clears to 0. The other register keeps its value unless its own clock also rises.
- R9: Both clocks may rise together. With both selects live, both registers then load the same bus value. With a stored select, each register takes its pin value from before the edge: A loads the old B-side register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a2b_clk | input | 1 | Capture clock of the A-side register |
| b2a_clk | input | 1 | Capture clock of the B-side register |
| rst_n | input | 1 | Synchronous active-low reset, sampled by each capture clock |
| a2b_en | input | 1 | Active-high enable of the drive onto B |
| b2a_en_n | input | 1 | Active-low enable of the drive onto A |
| a2b_use_reg | input | 1 | 1: B gets the A-side register, 0: B gets live A data |
| b2a_use_reg | input | 1 | 1: A gets the B-side register, 0: A gets live B data |
| a_pad_i | input | DATA_W | External value on the A bus |
| a_pad_o | output | DATA_W | Value the block drives onto A |
| a_pad_oe | output | 1 | Block drives A when 1 |
| b_pad_i | input | DATA_W | External value on the B bus |
| b_pad_o | output | DATA_W | Value the block drives onto B |
| b_pad_oe | output | 1 | Block drives B when 1 |

## Verification
The assertions are sampled on `a2b_clk` edges. They assume that controls and pad inputs are steady around each edge, and that external sources release a bus whenever the block drives it. The bench changes every input only while both clocks are low, half a period away from any edge.

The bench treats a `*_pad_i` value as meaningless whenever the matching `*_pad_oe` is high. This matches the model, in which a driven pin takes the block's own value. In the random phase the bench also scrambles both pad inputs while the feedback loop is formed, to show that the held value does not depend on them.

// File: rtl/xcvr_pkg.sv
// Package: shared control types for the registered bus transceiver.
// Assumes one enable and one source select per transfer direction.
package xcvr_pkg;

    // Decoded controls of one direction: drive enable (active high) and source
    typedef struct packed {
        logic drive;    // direction drives its destination bus
        logic use_reg;  // 1: stored register, 0: live opposite bus
    } dir_ctrl_t;

    // True when both directions drive live data, so each bus feeds the other
    function automatic logic loop_formed(input dir_ctrl_t ab, input dir_ctrl_t ba);
        return ab.drive && ba.drive && !ab.use_reg && !ba.use_reg;
    endfunction

endpackage

// File: rtl/xcvr_capture_reg.sv
// Capture register: samples a resolved bus pin on every rising edge of its
// own clock, independent of drive enables and selects.
// Assumes a synchronous active-low reset sampled by the same clock.
module xcvr_capture_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] pin,
    output logic [DATA_W-1:0] q
);

    // Store the pin value, or clear it while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= pin;
    end

    // Every edge out of reset loads the value the pin held at that edge
    assert_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (q == $past(pin)));

endmodule

// File: rtl/xcvr_keeper.sv
// Bus keeper: while the two directions form a live loop, holds the A-bus
// value seen just before the loop closed, standing in for the pair of
// back-to-back drivers. Transparent whenever the loop is open.
// Assumes external sources are released while the loop is formed.
module xcvr_keeper #(
    parameter int DATA_W = 8
) (
    input  xcvr_pkg::dir_ctrl_t ctl_ab,
    input  xcvr_pkg::dir_ctrl_t ctl_ba,
    input  logic [DATA_W-1:0]   a_ext,
    input  logic [DATA_W-1:0]   b_ext,
    input  logic [DATA_W-1:0]   reg_b,
    output logic                loop,
    output logic [DATA_W-1:0]   held
);
    import xcvr_pkg::*;

    // Flag the live loop for the output multiplexers
    always_comb begin
        loop = loop_formed(ctl_ab, ctl_ba);
    end

    // Follow the A-bus value while the loop is open; freeze it once closed.
    // The condition is re-derived here so one process sees a single input set.
    always_latch begin
        if (!loop_formed(ctl_ab, ctl_ba)) begin
            if (!ctl_ba.drive)      held <= a_ext;
            else if (ctl_ba.use_reg) held <= reg_b;
            else                    held <= b_ext;
        end
    end

endmodule

// File: rtl/xcvr_dir_path.sv
// One transfer direction: picks live, stored or kept data for its
// destination bus and passes its drive enable through.
// Assumes the enable has already been converted to active high.
module xcvr_dir_path #(
    parameter int DATA_W = 8
) (
    input  xcvr_pkg::dir_ctrl_t ctl,
    input  logic                loop,
    input  logic [DATA_W-1:0]   live,
    input  logic [DATA_W-1:0]   stored,
    input  logic [DATA_W-1:0]   kept,
    output logic [DATA_W-1:0]   pad_o,
    output logic                pad_oe
);

    // Choose the data source for the destination bus
    always_comb begin
        if (loop)             pad_o = kept;
        else if (ctl.use_reg) pad_o = stored;
        else                  pad_o = live;
    end

    // Pass the decoded enable to the pad
    always_comb begin
        pad_oe = ctl.drive;
    end

endmodule

// File: rtl/xcvr_reg_transceiver.sv
// Registered bidirectional bus transceiver between buses A and B.
// Two independently clocked capture registers, a live/stored multiplexer
// per direction, opposite-polarity enables and a keeper for the live loop.
// Assumes pads are resolved outside: a driven pin reads back its own drive.
module xcvr_reg_transceiver #(
    parameter int DATA_W = 8
) (
    input  logic              a2b_clk,
    input  logic              b2a_clk,
    input  logic              rst_n,
    input  logic              a2b_en,
    input  logic              b2a_en_n,
    input  logic              a2b_use_reg,
    input  logic              b2a_use_reg,
    input  logic [DATA_W-1:0] a_pad_i,
    output logic [DATA_W-1:0] a_pad_o,
    output logic              a_pad_oe,
    input  logic [DATA_W-1:0] b_pad_i,
    output logic [DATA_W-1:0] b_pad_o,
    output logic              b_pad_oe
);
    import xcvr_pkg::*;

    dir_ctrl_t         ctl_ab;
    dir_ctrl_t         ctl_ba;
    logic              loop;
    logic [DATA_W-1:0] held;
    logic [DATA_W-1:0] reg_a_q;
    logic [DATA_W-1:0] reg_b_q;
    logic [DATA_W-1:0] a_pin;
    logic [DATA_W-1:0] b_pin;

    // Decode enables to active high and attach the selects
    always_comb begin
        ctl_ab.drive   = a2b_en;
        ctl_ab.use_reg = a2b_use_reg;
        ctl_ba.drive   = !b2a_en_n;
        ctl_ba.use_reg = b2a_use_reg;
    end

    // Resolve each pin: own drive when output, external value otherwise
    always_comb begin
        a_pin = a_pad_oe ? a_pad_o : a_pad_i;
        b_pin = b_pad_oe ? b_pad_o : b_pad_i;
    end

    xcvr_capture_reg #(.DATA_W(DATA_W)) u_reg_a (
        .clk(a2b_clk), .rst_n(rst_n), .pin(a_pin), .q(reg_a_q));

    xcvr_capture_reg #(.DATA_W(DATA_W)) u_reg_b (
        .clk(b2a_clk), .rst_n(rst_n), .pin(b_pin), .q(reg_b_q));

    xcvr_keeper #(.DATA_W(DATA_W)) u_keep (
        .ctl_ab(ctl_ab), .ctl_ba(ctl_ba), .a_ext(a_pad_i), .b_ext(b_pad_i),
        .reg_b(reg_b_q), .loop(loop), .held(held));

    xcvr_dir_path #(.DATA_W(DATA_W)) u_path_ab (
        .ctl(ctl_ab), .loop(loop), .live(a_pad_i), .stored(reg_a_q),
        .kept(held), .pad_o(b_pad_o), .pad_oe(b_pad_oe));

    xcvr_dir_path #(.DATA_W(DATA_W)) u_path_ba (
        .ctl(ctl_ba), .loop(loop), .live(b_pad_i), .stored(reg_b_q),
        .kept(held), .pad_o(a_pad_o), .pad_oe(a_pad_oe));

    // Isolation pattern leaves both pads undriven
    assert_isolate_R2: assert property (@(posedge a2b_clk) disable iff (!rst_n)
        (!a2b_en && b2a_en_n) |-> (!a_pad_oe && !b_pad_oe));

    // Live A-to-B without a loop passes A straight through
    assert_live_R4: assert property (@(posedge a2b_clk) disable iff (!rst_n)
        (a2b_en && !a2b_use_reg && b2a_en_n) |-> (b_pad_o == a_pad_i));

    // Stored A-to-B shows the A-side register
    assert_stored_R5: assert property (@(posedge a2b_clk) disable iff (!rst_n)
        (a2b_en && a2b_use_reg) |-> (b_pad_o == reg_a_q));

    // In the loop both buses carry one value, steady while the loop lasts
    assert_loop_R6: assert property (@(posedge a2b_clk) disable iff (!rst_n)
        loop |-> (a_pad_o == b_pad_o));

    assert_hold_R6: assert property (@(posedge a2b_clk) disable iff (!rst_n)
        (loop && $past(loop)) |-> $stable(b_pad_o));

endmodule

// File: tb/tb_xcvr_reg_transceiver.sv
module tb_xcvr_reg_transceiver;
    localparam int W = 8;
    localparam int CLK_PERIOD = 10;

    logic         a2b_clk = 0, b2a_clk = 0, rst_n = 0;
    logic         a2b_en = 0, b2a_en_n = 1, a2b_use_reg = 0, b2a_use_reg = 0;
    logic [W-1:0] a_i = '0, b_i = '0;
    logic [W-1:0] a_pad_o, b_pad_o;
    logic         a_pad_oe, b_pad_oe;

    int n_cmp = 0, n_bad = 0;
    logic [W-1:0] ma = '0, mb = '0, mkeep = '0;

    xcvr_reg_transceiver #(.DATA_W(W)) dut (
        .a2b_clk(a2b_clk), .b2a_clk(b2a_clk), .rst_n(rst_n),
        .a2b_en(a2b_en), .b2a_en_n(b2a_en_n),
        .a2b_use_reg(a2b_use_reg), .b2a_use_reg(b2a_use_reg),
        .a_pad_i(a_i), .a_pad_o(a_pad_o), .a_pad_oe(a_pad_oe),
        .b_pad_i(b_i), .b_pad_o(b_pad_o), .b_pad_oe(b_pad_oe));

    function automatic logic m_loop();
        return a2b_en && !b2a_en_n && !a2b_use_reg && !b2a_use_reg;
    endfunction
    function automatic logic [W-1:0] exp_b();
        return m_loop() ? mkeep : (a2b_use_reg ? ma : a_i);
    endfunction
    function automatic logic [W-1:0] exp_a();
        return m_loop() ? mkeep : (b2a_use_reg ? mb : b_i);
    endfunction
    function automatic logic [W-1:0] a_bus();
        return !b2a_en_n ? exp_a() : a_i;
    endfunction
    function automatic logic [W-1:0] b_bus();
        return a2b_en ? exp_b() : b_i;
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic settle();
        #1;
        if (!m_loop()) mkeep = a_bus();
    endtask

    task automatic apply(input logic en, input logic en_n, input logic sab,
                         input logic sba, input logic [W-1:0] ai, input logic [W-1:0] bi);
        a2b_en = en; b2a_en_n = en_n; a2b_use_reg = sab; b2a_use_reg = sba;
        a_i = ai; b_i = bi;
        settle();
    endtask

    task automatic pulse(input bit ab, input bit ba);
        logic [W-1:0] na, nb;
        na = rst_n ? a_bus() : '0;
        nb = rst_n ? b_bus() : '0;
        #(CLK_PERIOD/2 - 1);
        if (ab) a2b_clk = 1;
        if (ba) b2a_clk = 1;
        if (ab) ma = na;
        if (ba) mb = nb;
        #(CLK_PERIOD/2);
        a2b_clk = 0; b2a_clk = 0;
        settle();
    endtask

    task automatic check_outputs(input string req);
        #1;
        chk({req, "/R3 b_oe"}, {7'd0, b_pad_oe}, {7'd0, a2b_en});
        chk({req, "/R3 a_oe"}, {7'd0, a_pad_oe}, {7'd0, !b2a_en_n});
        if (a2b_en)    chk({req, " b_out"}, b_pad_o, exp_b());
        if (!b2a_en_n) chk({req, " a_out"}, a_pad_o, exp_a());
    endtask

    // Read both registers through the stored-both mode (not for loop state)
    task automatic peek(input string req, input logic [W-1:0] ea, input logic [W-1:0] eb);
        logic e, en_n, sab, sba;
        e = a2b_en; en_n = b2a_en_n; sab = a2b_use_reg; sba = b2a_use_reg;
        apply(1, 0, 1, 1, a_i, b_i);
        #1;
        chk({req, " regA"}, b_pad_o, ea);
        chk({req, " regB"}, a_pad_o, eb);
        chk({req, " model regA"}, ma, ea);
        chk({req, " model regB"}, mb, eb);
        apply(e, en_n, sab, sba, a_i, b_i);
    endtask

    function automatic string mode_tag(input logic sel);
        if (m_loop()) return "R6";
        return sel ? "R5" : "R4";
    endfunction

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        // R8: reset clears both registers
        a_i = 8'hFF; b_i = 8'hEE;
        pulse(1, 1);
        rst_n = 1; settle();
        peek("R8 reset", 8'h00, 8'h00);

        // R2 / R3: isolation, then each enable alone
        apply(0, 1, 0, 0, 8'h11, 8'h22);
        check_outputs("R2");
        apply(1, 1, 0, 0, 8'h5A, 8'h22);
        check_outputs("R3 ab-only R4");
        chk("R4 live A to B", b_pad_o, 8'h5A);
        apply(0, 0, 0, 0, 8'h11, 8'hC4);
        check_outputs("R3 ba-only R4");
        chk("R4 live B to A", a_pad_o, 8'hC4);

        // R1: capture while isolated, simultaneous clocks
        apply(0, 1, 1, 1, 8'hA5, 8'h3C);
        pulse(1, 1);
        peek("R1 isolated capture", 8'hA5, 8'h3C);

        // R5: stored both ways at once
        apply(1, 0, 1, 1, 8'h00, 8'hFF);
        check_outputs("R5");
        chk("R5 stored to B", b_pad_o, 8'hA5);
        chk("R5 stored to A", a_pad_o, 8'h3C);

        // R7: A drives B live, B clock stores A data; then A clock too
        apply(1, 1, 0, 1, 8'h5A, 8'h00);
        pulse(0, 1);
        pulse(1, 0);
        peek("R7 A in both", 8'h5A, 8'h5A);
        // R7: B in both registers via stored B-to-A, staggered clocks
        apply(0, 0, 0, 1, 8'h00, 8'hC3);
        pulse(0, 1);
        chk("R7 A shows new regB", a_pad_o, 8'hC3);
        pulse(1, 0);
        peek("R7 B in both", 8'hC3, 8'hC3);

        // R9: simultaneous clocks, live select
        apply(1, 1, 0, 0, 8'h77, 8'h00);
        pulse(1, 1);
        peek("R9 live simultaneous", 8'h77, 8'h77);
        // R9: simultaneous clocks with stored select: A gets old regB
        apply(0, 0, 0, 1, 8'h00, 8'h99);
        pulse(1, 1);
        peek("R9 stored simultaneous", 8'h77, 8'h99);

        // R6: loop entered from A-to-B live, keeper holds A value
        apply(1, 1, 0, 0, 8'h3E, 8'h00);
        apply(1, 0, 0, 0, 8'h3E, 8'h00);
        check_outputs("R6 enter");
        chk("R6 hold A side", a_pad_o, 8'h3E);
        for (int i = 0; i < 4; i++) begin
            apply(1, 0, 0, 0, W'($urandom), W'($urandom));
            chk("R6 ignores pads A", a_pad_o, 8'h3E);
            chk("R6 ignores pads B", b_pad_o, 8'h3E);
        end
        pulse(1, 1);
        check_outputs("R6 after capture");
        apply(1, 0, 1, 1, 8'h00, 8'h00);
        peek("R6 captured held", 8'h3E, 8'h3E);
        // R6: loop entered from B-to-A live
        apply(0, 0, 0, 0, 8'h00, 8'h81);
        apply(1, 0, 0, 0, 8'h00, 8'h81);
        apply(1, 0, 0, 0, 8'h12, 8'h34);
        chk("R6 hold from B entry", b_pad_o, 8'h81);

        // R8: reset with only the A clock clears only regA
        apply(0, 1, 0, 0, 8'h4D, 8'h6E);
        pulse(1, 1);
        rst_n = 0; settle();
        pulse(1, 0);
        rst_n = 1; settle();
        peek("R8 one-side reset", 8'h00, 8'h6E);

        // Random phase: all control patterns, random clocks
        for (int i = 0; i < 400; i++) begin
            int act;
            apply(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                  W'($urandom), W'($urandom));
            act = $urandom_range(0, 3);
            if (act == 1) pulse(1, 0);
            else if (act == 2) pulse(0, 1);
            else if (act == 3) pulse(1, 1);
            #1;
            chk("R3 rand b_oe", {7'd0, b_pad_oe}, {7'd0, a2b_en});
            chk("R3 rand a_oe", {7'd0, a_pad_oe}, {7'd0, !b2a_en_n});
            if (a2b_en)    chk({mode_tag(a2b_use_reg), " R1 rand b_out"}, b_pad_o, exp_b());
            if (!b2a_en_n) chk({mode_tag(b2a_use_reg), " R1 rand a_out"}, a_pad_o, exp_a());
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule